// File: doc/BRIEF.md
# VRAM Change-Tracking Bitmap Unit

This unit keeps the bookkeeping that decides which words of a 512-word video memory still have to be copied to a remote device. It holds four pieces of state. The first is a fine change bitmap with one bit per memory word. The second is a coarse summary bitmap in which each bit stands for a group of 16 words. The third is a lock bitmap with one bit per word. The fourth is a single need-paint flag. The memory array and the transport that carries the words are outside the block.

A producer works through three kinds of bitmap-word writes. A lock store overwrites one lock word. A change OR sets bits in one fine word. A summary OR sets bits in the coarse word. Every bitmap word is ordered MSB-first: the most significant bit covers the lowest address. The producer is expected to lock, write the data, OR in the fine bits, OR in the summary bits and then drop the locks.

A consumer sees the lowest-addressed dirty word that belongs to a group whose summary bit is set. It sends that word and then acknowledges it, which clears the word's change bit. A separate query port answers whether a given word is known to be in sync with the remote copy.

Top module: `vram_dirty_tracker`

## Requirements
- R1: After reset every change, summary and lock bit is zero. In that state `need_paint` is 0, `cons_valid` is 0, `cons_idle` is 1 and `q_sync` is 1 for every address.
- R2: A change OR to fine word k with data bit b set marks address k*MAP_W + (MAP_W-1-b) as changed. Bits already set in the map stay set.
- R3: A lock store to word k replaces all MAP_W lock bits of that word, using the same MSB-first mapping as R2. Lock bits in other words are not touched.
- R4: `q_sync` is 1 for address `q_addr` exactly when both its lock bit and its change bit are zero. It follows the registered state in the same cycle.
- R5: Summary bit c covers addresses (MAP_W-1-c)*GROUP up to (MAP_W-1-c)*GROUP+GROUP-1. A changed word is reported only while its group's summary bit is set.
- R6: While any reportable word exists, `cons_valid` is 1 and `cons_addr` is the lowest such address. A set lock bit does not hold a word back from being reported.
- R7: `cons_ack` while `cons_valid` is 1 clears the change bit of the reported word at that clock edge. From the next cycle the port reports the next dirty word.
- R8: If a change OR sets the same word in the cycle it is acknowledged, the change bit stays set.
- R9: A summary bit clears by itself one edge after the last change bit of its group has cleared, and never while any of those change bits is set. `cons_idle` is 1 exactly when the summary map is zero, which makes it 1 within two edges of the last acknowledge when the producer is quiet.
- R10: `need_paint` is set by `prd_paint_req` or by a lock store with nonzero data. It is cleared only by `paint_done`. When a set and a clear arrive together, the set wins. A lock store of all zeros leaves the flag unchanged.
- R11: `cons_ack` has no effect while `cons_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prd_lock_we | input | 1 | Store `prd_lock_data` into lock word `prd_lock_idx` |
| prd_lock_idx | input | IDX_W | Lock bitmap word index |
| prd_lock_data | input | MAP_W | Lock word value, MSB-first |
| prd_chg_we | input | 1 | OR `prd_chg_data` into fine change word `prd_chg_idx` |
| prd_chg_idx | input | IDX_W | Fine change bitmap word index |
| prd_chg_data | input | MAP_W | Change bits to set, MSB-first |
| prd_sum_we | input | 1 | OR `prd_sum_data` into the summary word |
| prd_sum_data | input | MAP_W | Summary bits to set, MSB-first |
| prd_paint_req | input | 1 | Set the need-paint flag directly |
| paint_done | input | 1 | Paint command; clears the need-paint flag |
| cons_ack | input | 1 | Reported word has been sent |
| cons_valid | output | 1 | A dirty word is being reported |
| cons_addr | output | ADDR_W | Address of the reported word |
| cons_idle | output | 1 | Summary map is empty |
| q_addr | input | ADDR_W | Address for the sync query |
| q_sync | output | 1 | Queried word is known to be in sync |
| need_paint | output | 1 | Need-paint flag |

## Verification
The hardest situation to reach is the race at a single clock edge. In it, a producer OR and a consumer acknowledge hit the same word. Alongside it is the one-cycle window in which a summary bit is still set but its group has already drained. The bench reaches the race by raising `cons_ack` and a change OR for the reported address in the same cycle. It reaches the window by sampling `cons_idle` in the cycle right after the final acknowledge and again one cycle later. It runs on a 64-word configuration, so the producer-to-consumer round trip can be swept over every address and each bit position can be checked against its MSB-first mapping.

// File: rtl/dt_pkg.sv
package dt_pkg;

   // Operation applied to the need-paint flag in a cycle
   typedef enum logic [1:0] {
      PAINT_HOLD  = 2'd0,
      PAINT_SET   = 2'd1,
      PAINT_CLEAR = 2'd2
   } paint_op_e;

   // Bitmap words are MSB-first: lane 0 (lowest address) sits in the top bit
   function automatic int msb_lane(input int width, input int lane);
      return width - 1 - lane;
   endfunction

endpackage

// File: rtl/dt_lowest_set.sv
module dt_lowest_set #(
   parameter  int N = 32,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [W-1:0] idx
);

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end

endmodule

// File: rtl/dt_bit_map.sv
module dt_bit_map #(
   parameter  int ADDR_W     = 9,
   parameter  int MAP_W      = 32,
   parameter  bit STORE_MODE = 1'b0,
   localparam int WORDS      = 1 << ADDR_W,
   localparam int NW         = WORDS / MAP_W,
   localparam int IW         = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [MAP_W-1:0]  wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   output logic [WORDS-1:0]  bits
);

   logic [WORDS-1:0] word_sel;
   logic [WORDS-1:0] set_vec;
   logic [WORDS-1:0] wipe_vec;
   logic [WORDS-1:0] clr_vec;

   for (genvar w = 0; w < NW; w++) begin : g_word
      assign word_sel[w*MAP_W +: MAP_W] = {MAP_W{wr_en && (wr_idx == IW'(w))}};
      for (genvar b = 0; b < MAP_W; b++) begin : g_lane
         localparam int LANE = dt_pkg::msb_lane(MAP_W, b);
         assign set_vec[w*MAP_W + b] = word_sel[w*MAP_W + b] & wr_data[LANE];
      end
   end

   // Store variant replaces the whole addressed word; OR variant only adds
   if (STORE_MODE) begin : g_store
      assign wipe_vec = word_sel;
   end else begin : g_or
      assign wipe_vec = '0;
   end

   always_comb begin
      clr_vec           = '0;
      clr_vec[clr_addr] = clr_en;
   end

   // A set in the same cycle as a clear wins
   always_ff @(posedge clk) begin
      if (!rst_n) bits <= '0;
      else        bits <= (bits & ~wipe_vec & ~clr_vec) | set_vec;
   end

endmodule

// File: rtl/dt_summary.sv
module dt_summary #(
   parameter  int ADDR_W = 9,
   parameter  int MAP_W  = 32,
   parameter  int GROUP  = 16,
   localparam int WORDS  = 1 << ADDR_W,
   localparam int GROUPS = WORDS / GROUP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sum_we,
   input  logic [MAP_W-1:0]  sum_data,
   input  logic [WORDS-1:0]  fine_bits,
   output logic [GROUPS-1:0] sum_bits,
   output logic [GROUPS-1:0] live
);

   logic [GROUPS-1:0] set_vec;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      localparam int LANE = dt_pkg::msb_lane(MAP_W, g);
      assign live[g]    = |fine_bits[g*GROUP +: GROUP];
      assign set_vec[g] = sum_we & sum_data[LANE];
   end

   // A group bit falls only once its fine bits have all been cleared
   always_ff @(posedge clk) begin
      if (!rst_n) sum_bits <= '0;
      else        sum_bits <= (sum_bits & live) | set_vec;
   end

endmodule

// File: rtl/dt_scanner.sv
module dt_scanner #(
   parameter  int ADDR_W = 9,
   parameter  int GROUP  = 16,
   localparam int WORDS  = 1 << ADDR_W,
   localparam int GROUPS = WORDS / GROUP,
   localparam int GW     = $clog2(GROUPS),
   localparam int OW     = $clog2(GROUP)
) (
   input  logic [WORDS-1:0]  fine_bits,
   input  logic [GROUPS-1:0] sum_bits,
   input  logic [GROUPS-1:0] live,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic              idle
);

   logic [GROUPS-1:0] cand;
   logic [GW-1:0]     grp_idx;
   logic [GROUP-1:0]  grp_slice;
   logic [OW-1:0]     off_idx;
   logic              off_found;

   assign cand = sum_bits & live;

   dt_lowest_set #(.N(GROUPS)) grp_pick_i (
      .vec   (cand),
      .found (valid),
      .idx   (grp_idx)
   );

   assign grp_slice = fine_bits[{grp_idx, OW'(0)} +: GROUP];

   dt_lowest_set #(.N(GROUP)) off_pick_i (
      .vec   (grp_slice),
      .found (off_found),
      .idx   (off_idx)
   );

   assign addr = off_found ? {grp_idx, off_idx} : '0;
   assign idle = ~|sum_bits;

endmodule

// File: rtl/vram_dirty_tracker.sv
module vram_dirty_tracker #(
   parameter  int ADDR_W = 9,
   parameter  int MAP_W  = 32,
   parameter  int GROUP  = 16,
   localparam int WORDS  = 1 << ADDR_W,
   localparam int NW     = WORDS / MAP_W,
   localparam int IDX_W  = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prd_lock_we,
   input  logic [IDX_W-1:0]  prd_lock_idx,
   input  logic [MAP_W-1:0]  prd_lock_data,
   input  logic              prd_chg_we,
   input  logic [IDX_W-1:0]  prd_chg_idx,
   input  logic [MAP_W-1:0]  prd_chg_data,
   input  logic              prd_sum_we,
   input  logic [MAP_W-1:0]  prd_sum_data,
   input  logic              prd_paint_req,
   input  logic              paint_done,
   input  logic              cons_ack,
   output logic              cons_valid,
   output logic [ADDR_W-1:0] cons_addr,
   output logic              cons_idle,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_sync,
   output logic              need_paint
);
   import dt_pkg::*;

   localparam int GROUPS = WORDS / GROUP;

   if (GROUP < 2 || (1 << $clog2(GROUP)) != GROUP) begin : g_bad_group
      $error("GROUP must be a power of two of at least 2");
   end
   if (GROUPS != MAP_W) begin : g_bad_summary
      $error("summary map must be exactly one bitmap word wide");
   end
   if (NW * MAP_W != WORDS) begin : g_bad_map
      $error("MAP_W must divide the word count");
   end

   logic [WORDS-1:0]  fine_bits;
   logic [WORDS-1:0]  lock_bits;
   logic [GROUPS-1:0] sum_bits;
   logic [GROUPS-1:0] live;
   logic              ack_fire;
   logic              paint_src;
   paint_op_e         paint_op;

   assign ack_fire = cons_ack & cons_valid;

   dt_bit_map #(.ADDR_W(ADDR_W), .MAP_W(MAP_W), .STORE_MODE(1'b0)) fine_map_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (prd_chg_we),
      .wr_idx   (prd_chg_idx),
      .wr_data  (prd_chg_data),
      .clr_en   (ack_fire),
      .clr_addr (cons_addr),
      .bits     (fine_bits)
   );

   dt_bit_map #(.ADDR_W(ADDR_W), .MAP_W(MAP_W), .STORE_MODE(1'b1)) lock_map_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (prd_lock_we),
      .wr_idx   (prd_lock_idx),
      .wr_data  (prd_lock_data),
      .clr_en   (1'b0),
      .clr_addr ('0),
      .bits     (lock_bits)
   );

   dt_summary #(.ADDR_W(ADDR_W), .MAP_W(MAP_W), .GROUP(GROUP)) summary_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sum_we    (prd_sum_we),
      .sum_data  (prd_sum_data),
      .fine_bits (fine_bits),
      .sum_bits  (sum_bits),
      .live      (live)
   );

   dt_scanner #(.ADDR_W(ADDR_W), .GROUP(GROUP)) scanner_i (
      .fine_bits (fine_bits),
      .sum_bits  (sum_bits),
      .live      (live),
      .valid     (cons_valid),
      .addr      (cons_addr),
      .idle      (cons_idle)
   );

   assign q_sync = ~lock_bits[q_addr] & ~fine_bits[q_addr];

   assign paint_src = prd_paint_req | (prd_lock_we & (|prd_lock_data));

   always_comb begin
      if (paint_src)       paint_op = PAINT_SET;
      else if (paint_done) paint_op = PAINT_CLEAR;
      else                 paint_op = PAINT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) need_paint <= 1'b0;
      else begin
         case (paint_op)
            PAINT_SET:   need_paint <= 1'b1;
            PAINT_CLEAR: need_paint <= 1'b0;
            default:     need_paint <= need_paint;
         endcase
      end
   end

endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
   parameter  int ADDR_W = 9,
   parameter  int MAP_W  = 32,
   parameter  int GROUP  = 16,
   localparam int WORDS  = 1 << ADDR_W,
   localparam int GROUPS = WORDS / GROUP,
   localparam int OW     = $clog2(GROUP)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prd_lock_we,
   input logic [MAP_W-1:0]  prd_lock_data,
   input logic              prd_chg_we,
   input logic              prd_paint_req,
   input logic              paint_done,
   input logic              cons_ack,
   input logic              cons_valid,
   input logic [ADDR_W-1:0] cons_addr,
   input logic              cons_idle,
   input logic              need_paint,
   input logic [WORDS-1:0]  fine_bits,
   input logic [GROUPS-1:0] sum_bits
);

   logic paint_in;
   assign paint_in = prd_paint_req | (prd_lock_we & (|prd_lock_data));

   // R6
   valid_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cons_valid |-> fine_bits[cons_addr]);

   // R5
   valid_needs_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cons_valid |-> sum_bits[cons_addr >> OW]);

   // R9
   idle_excludes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cons_idle |-> !cons_valid);

   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_ack && cons_valid && !prd_chg_we) |=> !fine_bits[$past(cons_addr)]);

   // R10
   paint_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(need_paint) |-> $past(paint_in));

   // R10
   paint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paint_done && !paint_in) |=> !need_paint);

   for (genvar g = 0; g < GROUPS; g++) begin : g_hold
      // R9
      summary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sum_bits[g]) |-> ($past(fine_bits[g*GROUP +: GROUP]) == '0));
   end

endmodule

bind vram_dirty_tracker dt_checker #(.ADDR_W(ADDR_W), .MAP_W(MAP_W), .GROUP(GROUP)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .prd_lock_we   (prd_lock_we),
   .prd_lock_data (prd_lock_data),
   .prd_chg_we    (prd_chg_we),
   .prd_paint_req (prd_paint_req),
   .paint_done    (paint_done),
   .cons_ack      (cons_ack),
   .cons_valid    (cons_valid),
   .cons_addr     (cons_addr),
   .cons_idle     (cons_idle),
   .need_paint    (need_paint),
   .fine_bits     (fine_bits),
   .sum_bits      (sum_bits)
);

// File: tb/vram_dirty_tracker_tb.sv
module vram_dirty_tracker_tb_top;

   localparam int AW = 6;
   localparam int MW = 8;
   localparam int GR = 8;
   localparam int NA = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          prd_lock_we = 1'b0;
   logic [2:0]    prd_lock_idx = '0;
   logic [MW-1:0] prd_lock_data = '0;
   logic          prd_chg_we = 1'b0;
   logic [2:0]    prd_chg_idx = '0;
   logic [MW-1:0] prd_chg_data = '0;
   logic          prd_sum_we = 1'b0;
   logic [MW-1:0] prd_sum_data = '0;
   logic          prd_paint_req = 1'b0;
   logic          paint_done = 1'b0;
   logic          cons_ack = 1'b0;
   logic          cons_valid;
   logic [AW-1:0] cons_addr;
   logic          cons_idle;
   logic [AW-1:0] q_addr = '0;
   logic          q_sync;
   logic          need_paint;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vram_dirty_tracker #(.ADDR_W(AW), .MAP_W(MW), .GROUP(GR)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .prd_lock_we(prd_lock_we), .prd_lock_idx(prd_lock_idx), .prd_lock_data(prd_lock_data),
      .prd_chg_we(prd_chg_we), .prd_chg_idx(prd_chg_idx), .prd_chg_data(prd_chg_data),
      .prd_sum_we(prd_sum_we), .prd_sum_data(prd_sum_data),
      .prd_paint_req(prd_paint_req), .paint_done(paint_done),
      .cons_ack(cons_ack), .cons_valid(cons_valid), .cons_addr(cons_addr),
      .cons_idle(cons_idle), .q_addr(q_addr), .q_sync(q_sync), .need_paint(need_paint)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Advance one edge, then drop every strobe
   task automatic tick();
      @(posedge clk);
      #1;
      prd_lock_we = 1'b0; prd_chg_we = 1'b0; prd_sum_we = 1'b0;
      prd_paint_req = 1'b0; paint_done = 1'b0; cons_ack = 1'b0;
   endtask

   task automatic set_chg(input int a);
      prd_chg_we   = 1'b1;
      prd_chg_idx  = 3'(a / MW);
      prd_chg_data = MW'(8'h80 >> (a % MW));
      tick();
   endtask

   task automatic set_sum(input int g);
      prd_sum_we   = 1'b1;
      prd_sum_data = MW'(8'h80 >> g);
      tick();
   endtask

   task automatic store_lock(input int w, input logic [MW-1:0] d);
      prd_lock_we   = 1'b1;
      prd_lock_idx  = 3'(w);
      prd_lock_data = d;
      tick();
   endtask

   task automatic ack();
      cons_ack = 1'b1;
      tick();
   endtask

   task automatic query(input int a, output int s);
      q_addr = AW'(a);
      #1;
      s = int'(q_sync);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int s;
      logic [NA-1:0] m;
      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check("R1 valid", int'(cons_valid), 0);
      check("R1 idle", int'(cons_idle), 1);
      check("R1 need_paint", int'(need_paint), 0);
      for (int a = 0; a < NA; a++) begin
         query(a, s);
         check("R1 q_sync", s, 1);
      end

      // R2 R5 R6 R7 R9: round trip for every address
      for (int a = 0; a < NA; a++) begin
         set_chg(a);
         query(a, s);
         check("R2 marked", s, 0);
         check("R5 gated without summary", int'(cons_valid), 0);
         set_sum(a / GR);
         check("R6 valid", int'(cons_valid), 1);
         check("R6 addr", int'(cons_addr), a);
         ack();
         query(a, s);
         check("R7 cleared", s, 1);
         check("R7 drained", int'(cons_valid), 0);
         tick();
         check("R9 idle", int'(cons_idle), 1);
      end

      // R6 R7: ascending drain of scattered patterns
      for (int p = 0; p < 2; p++) begin
         m = '0;
         for (int i = 0; i < 10; i++) begin
            int a;
            a = (i * ((p == 0) ? 13 : 29) + ((p == 0) ? 5 : 3)) % NA;
            set_chg(a);
            m[a] = 1'b1;
         end
         prd_sum_we = 1'b1; prd_sum_data = '1; tick();
         while (m != '0) begin
            int e;
            e = -1;
            for (int k = NA - 1; k >= 0; k--) if (m[k]) e = k;
            check("R6 order valid", int'(cons_valid), 1);
            check("R6 order addr", int'(cons_addr), e);
            ack();
            m[e] = 1'b0;
         end
         check("R7 pattern drained", int'(cons_valid), 0);
         tick();
         check("R9 pattern idle", int'(cons_idle), 1);
      end

      // R3 R4 R10: lock store
      store_lock(2, 8'hA0);
      check("R10 lock sets paint", int'(need_paint), 1);
      for (int a = 0; a < NA; a++) begin
         query(a, s);
         check("R3 lock map", s, (a == 16 || a == 18) ? 0 : 1);
      end
      set_chg(16);
      set_sum(2);
      check("R6 lock no block valid", int'(cons_valid), 1);
      check("R6 lock no block addr", int'(cons_addr), 16);
      ack();
      query(16, s);
      check("R4 locked clean word", s, 0);
      store_lock(2, 8'h01);
      query(16, s);
      check("R3 overwrite released", s, 1);
      query(23, s);
      check("R3 overwrite locked", s, 0);
      store_lock(2, 8'h00);
      query(23, s);
      check("R4 unlocked", s, 1);
      tick();

      // R10: paint flag
      check("R10 held", int'(need_paint), 1);
      paint_done = 1'b1; tick();
      check("R10 cleared", int'(need_paint), 0);
      store_lock(5, 8'h00);
      check("R10 zero lock no set", int'(need_paint), 0);
      prd_paint_req = 1'b1; tick();
      check("R10 direct set", int'(need_paint), 1);
      paint_done = 1'b1; tick();
      check("R10 cleared again", int'(need_paint), 0);
      prd_paint_req = 1'b1; paint_done = 1'b1; tick();
      check("R10 set wins", int'(need_paint), 1);
      paint_done = 1'b1; tick();

      // R8: OR and acknowledge of the same word in one cycle
      set_chg(20);
      set_sum(2);
      check("R8 pre addr", int'(cons_addr), 20);
      cons_ack = 1'b1;
      prd_chg_we = 1'b1; prd_chg_idx = 3'd2; prd_chg_data = 8'h08;
      tick();
      check("R8 kept valid", int'(cons_valid), 1);
      check("R8 kept addr", int'(cons_addr), 20);
      ack();
      tick();
      check("R8 then idle", int'(cons_idle), 1);

      // R11: acknowledge without a report
      set_chg(30);
      ack();
      set_sum(3);
      check("R11 survived valid", int'(cons_valid), 1);
      check("R11 survived addr", int'(cons_addr), 30);
      ack();
      tick();

      // R9: summary held while group still dirty, exact idle timing
      set_chg(8);
      set_chg(9);
      set_sum(1);
      ack();
      tick(); tick(); tick();
      check("R9 hold valid", int'(cons_valid), 1);
      check("R9 hold addr", int'(cons_addr), 9);
      check("R9 hold not idle", int'(cons_idle), 0);
      ack();
      check("R9 last ack valid", int'(cons_valid), 0);
      check("R9 one edge not idle", int'(cons_idle), 0);
      tick();
      check("R9 second edge idle", int'(cons_idle), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule